// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block paces refresh work for an asynchronous page-mode DRAM array whose 1024 rows must each be refreshed at least once per retention window, in any order. It counts system clocks and raises a refresh request once per interval. The interval is the retention window divided by the row count, computed from a clock-frequency parameter and rounded down so that no refresh is ever late. A mode input selects either the standard 16 ms window (about 15.6 us per refresh) or the extended 128 ms window (about 125 us per refresh).

The access controller takes requests through a request/acknowledge handshake. Intervals that pass before the controller acknowledges are banked in a backlog counter, so deferred refreshes are made up later. When the backlog is full, an urgent flag tells the controller to service a refresh before anything else. For controllers that refresh with CAS-before-RAS cycles, the DRAM supplies the row itself. For controllers that strobe a row address alone, the block keeps a row counter that advances on every accepted refresh. Optionally, ordinary host read/write cycles can be credited against the backlog, because opening a row also refreshes it. This option is off by default.

Top module: `refresh_sched`

## Requirements
- R1: After reset, the backlog count is 0, request and urgent are low, the row output is 0 and the standard window is selected.
- R2: With the standard window, one refresh is added to the backlog every LS = floor(CLK_MHZ*STD_RET_US/ROWS) clocks. The first one appears LS clock edges after reset is released.
- R3: With the extended window, one refresh is added every LE = floor(CLK_MHZ*EXT_RET_US/ROWS) clocks.
- R4: `ref_req_o` is high exactly when the backlog count is non-zero.
- R5: An acknowledge while the backlog is non-zero lowers it by one on the next edge. An acknowledge while the backlog is zero is ignored: the count stays 0 and the row output does not move.
- R6: The backlog saturates at PEND_MAX (8 by default), and further intervals are dropped. `ref_urgent_o` is high exactly when the count equals PEND_MAX.
- R7: With row addressing enabled, the row output steps by one, modulo ROWS, on each accepted acknowledge and wraps from ROWS-1 to 0. With it disabled, the row output is held at 0.
- R8: The window-select input is captured only on edges where the backlog count is zero. A change made while refreshes are pending takes effect only after the backlog drains.
- R9: With COUNT_ACCESS=1, a pulse on `host_cycle_i` while the backlog is non-zero lowers it by one without moving the row output. With COUNT_ACCESS=0 the input has no effect.
- R10: An interval expiring on the same edge as an accepted acknowledge leaves the backlog unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_ret_i | input | 1 | 1 selects the extended retention window, 0 the standard one |
| ref_ack_i | input | 1 | Controller has performed one refresh |
| host_cycle_i | input | 1 | A normal host read/write cycle completed (credited only if COUNT_ACCESS=1) |
| ref_req_o | output | 1 | Refresh wanted; high while the backlog is non-zero |
| ref_urgent_o | output | 1 | Backlog full; the controller must refresh next |
| pend_cnt_o | output | PEND_W | Number of refreshes owed |
| ref_row_o | output | ROW_W | Row to strobe for RAS-only refresh |

## Verification
The bench targets the exact cycle on which each interval ends. An off-by-one interval counter would move every request by a clock, and rounding up instead of down would stretch the interval past the deadline. It drives the backlog into saturation and checks that an urgent flag is set and that no counter wraps back to zero, which would silently forget refreshes. It changes the window select while refreshes are pending, and it lines acknowledges up with interval ends. A design that retimes mid-backlog or counts both events at once shows a wrong count. It compares a credit-enabled instance with a credit-disabled CAS-before-RAS instance, so a host cycle that leaks into the wrong build, or that moves the row counter, is caught. The row counter is run through a full wrap.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

   // Clocks per refresh slot, rounded down so that slots are never late.
   function automatic int unsigned slot_clocks(input int unsigned clk_mhz,
                                               input int unsigned ret_us,
                                               input int unsigned rows);
      longint unsigned prod;
      prod = longint'(clk_mhz) * longint'(ret_us);
      return int'(prod / longint'(rows));
   endfunction

   typedef enum logic {
      WIN_STD = 1'b0,
      WIN_EXT = 1'b1
   } win_sel_e;

endpackage

// File: rtl/rs_tick_gen.sv
module rs_tick_gen
   import refresh_sched_pkg::*;
#(
   parameter int unsigned CLK_MHZ    = 50,
   parameter int unsigned ROWS       = 1024,
   parameter int unsigned STD_RET_US = 16000,
   parameter int unsigned EXT_RET_US = 128000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_i,
   input  logic idle_i,
   output logic tick_o,
   output logic win_o
);

   localparam int unsigned LIM_S = slot_clocks(CLK_MHZ, STD_RET_US, ROWS);
   localparam int unsigned LIM_E = slot_clocks(CLK_MHZ, EXT_RET_US, ROWS);
   localparam int unsigned CNT_W = $clog2(LIM_E + 1);
   localparam logic [CNT_W-1:0] END_S = CNT_W'(LIM_S - 1);
   localparam logic [CNT_W-1:0] END_E = CNT_W'(LIM_E - 1);

   if (LIM_S < 2) begin : g_bad_std
      $error("standard slot shorter than two clocks");
   end
   if (LIM_E < LIM_S) begin : g_bad_ext
      $error("extended window must not be shorter than standard");
   end

   win_sel_e         win_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] end_sel;

   assign end_sel = (win_q == WIN_EXT) ? END_E : END_S;
   assign tick_o  = (cnt_q >= end_sel);
   assign win_o   = win_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         win_q <= WIN_STD;
      end else begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
         if (idle_i) begin
            win_q <= win_sel_e'(win_i);
         end
      end
   end

endmodule

// File: rtl/rs_backlog.sv
module rs_backlog #(
   parameter int unsigned PEND_W       = 4,
   parameter int unsigned PEND_MAX     = 8,
   parameter bit          COUNT_ACCESS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ack_i,
   input  logic              host_i,
   output logic [PEND_W-1:0] pend_o,
   output logic              req_o,
   output logic              urgent_o,
   output logic              accept_o
);

   localparam logic [PEND_W-1:0] FULL = PEND_W'(PEND_MAX);

   logic [PEND_W-1:0] pend_q;
   logic [PEND_W-1:0] pend_nxt;
   logic              credit;
   logic              nz;
   logic              dec;

   if (COUNT_ACCESS) begin : g_credit
      assign credit = host_i;
   end else begin : g_no_credit
      logic unused_host;
      assign unused_host = host_i;
      assign credit      = 1'b0;
   end

   assign nz       = (pend_q != '0);
   assign dec      = (ack_i | credit) & nz;
   assign accept_o = ack_i & nz;

   always_comb begin
      pend_nxt = pend_q;
      unique case ({tick_i, dec})
         2'b10:   pend_nxt = (pend_q == FULL) ? pend_q : pend_q + 1'b1;
         2'b01:   pend_nxt = pend_q - 1'b1;
         default: pend_nxt = pend_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= pend_nxt;
      end
   end

   assign pend_o   = pend_q;
   assign req_o    = nz;
   assign urgent_o = (pend_q == FULL);

endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr #(
   parameter int unsigned ROW_W       = 10,
   parameter bit          ROW_ADDR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [ROW_W-1:0] row_o
);

   if (ROW_ADDR_EN) begin : g_row
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q <= '0;
         end else if (step_i) begin
            row_q <= row_q + 1'b1;
         end
      end
      assign row_o = row_q;
   end else begin : g_internal_row
      logic unused_row_in;
      assign unused_row_in = ^{clk, rst_n, step_i};
      assign row_o         = '0;
   end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter int unsigned CLK_MHZ      = 50,
   parameter int unsigned ROWS         = 1024,
   parameter int unsigned STD_RET_US   = 16000,
   parameter int unsigned EXT_RET_US   = 128000,
   parameter int unsigned PEND_W       = 4,
   parameter int unsigned PEND_MAX     = 8,
   parameter bit          ROW_ADDR_EN  = 1'b1,
   parameter bit          COUNT_ACCESS = 1'b0,
   parameter int unsigned ROW_W        = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_ret_i,
   input  logic              ref_ack_i,
   input  logic              host_cycle_i,
   output logic              ref_req_o,
   output logic              ref_urgent_o,
   output logic [PEND_W-1:0] pend_cnt_o,
   output logic [ROW_W-1:0]  ref_row_o
);

   if (ROWS != (1 << ROW_W)) begin : g_bad_rows
      $error("ROWS must equal 2**ROW_W");
   end
   if (PEND_MAX < 1 || PEND_MAX >= (1 << PEND_W)) begin : g_bad_pend
      $error("PEND_MAX must fit in PEND_W bits and be non-zero");
   end

   logic tick_w;
   logic ret_mode_w;
   logic accept_w;

   rs_tick_gen #(
      .CLK_MHZ   (CLK_MHZ),
      .ROWS      (ROWS),
      .STD_RET_US(STD_RET_US),
      .EXT_RET_US(EXT_RET_US)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .win_i (ext_ret_i),
      .idle_i(!ref_req_o),
      .tick_o(tick_w),
      .win_o (ret_mode_w)
   );

   rs_backlog #(
      .PEND_W      (PEND_W),
      .PEND_MAX    (PEND_MAX),
      .COUNT_ACCESS(COUNT_ACCESS)
   ) u_backlog (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_w),
      .ack_i   (ref_ack_i),
      .host_i  (host_cycle_i),
      .pend_o  (pend_cnt_o),
      .req_o   (ref_req_o),
      .urgent_o(ref_urgent_o),
      .accept_o(accept_w)
   );

   rs_row_ctr #(
      .ROW_W      (ROW_W),
      .ROW_ADDR_EN(ROW_ADDR_EN)
   ) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .step_i(accept_w),
      .row_o (ref_row_o)
   );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int unsigned PEND_W      = 4,
   parameter int unsigned PEND_MAX    = 8,
   parameter int unsigned ROW_W       = 10,
   parameter bit          ROW_ADDR_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              req,
   input logic              urgent,
   input logic [PEND_W-1:0] pend,
   input logic [ROW_W-1:0]  row,
   input logic              mode_q,
   input logic              tick
);

   AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PEND_W'(PEND_MAX)); // R6

   AST_URGENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urgent) |-> ($past(pend) == PEND_W'(PEND_MAX - 1)) && $past(tick)); // R6

   AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(tick)); // R2

   AST_ACK_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req && !tick) |=> (pend == $past(pend) - 1'b1)); // R5

   AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req && !tick) |=> (pend == '0) && $stable(row)); // R5

   AST_TICK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ack && req) |=> $stable(pend)); // R10

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> $stable(mode_q)); // R8

   if (ROW_ADDR_EN) begin : g_row_chk
      AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (ack && req) |=> (row == $past(row) + 1'b1)); // R7
   end else begin : g_row_zero
      AST_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (ack && req) |=> (row == '0)); // R7
   end

endmodule

bind refresh_sched refresh_sched_chk #(
   .PEND_W     (PEND_W),
   .PEND_MAX   (PEND_MAX),
   .ROW_W      (ROW_W),
   .ROW_ADDR_EN(ROW_ADDR_EN)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ack   (ref_ack_i),
   .req   (ref_req_o),
   .urgent(ref_urgent_o),
   .pend  (pend_cnt_o),
   .row   (ref_row_o),
   .mode_q(ret_mode_w),
   .tick  (tick_w)
);

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 1;
   localparam int ROWS       = 16;
   localparam int ROW_W      = 4;
   localparam int STD_US     = 260;
   localparam int EXT_US     = 1030;
   localparam int PEND_W     = 4;
   localparam int PEND_MAX   = 8;
   localparam int LIM_S      = CLK_MHZ * STD_US / ROWS;   // 16 (16.25 rounded down)
   localparam int LIM_E      = CLK_MHZ * EXT_US / ROWS;   // 64 (64.375 rounded down)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_in = 1'b0;
   logic ack = 1'b0;
   logic acc = 1'b0;

   logic              req_a, urg_a, req_c, urg_c;
   logic [PEND_W-1:0] pend_a, pend_c;
   logic [ROW_W-1:0]  row_a, row_c;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state: index 0 = credit-enabled row-address build, 1 = plain internal-row build
   int m_cnt[2];
   int m_pend[2];
   int m_mode[2];
   int m_row[2];

   always #(CLK_PERIOD/2) clk = ~clk;

   refresh_sched #(
      .CLK_MHZ(CLK_MHZ), .ROWS(ROWS), .STD_RET_US(STD_US), .EXT_RET_US(EXT_US),
      .PEND_W(PEND_W), .PEND_MAX(PEND_MAX), .ROW_ADDR_EN(1'b1), .COUNT_ACCESS(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_ret_i(mode_in), .ref_ack_i(ack), .host_cycle_i(acc),
      .ref_req_o(req_a), .ref_urgent_o(urg_a), .pend_cnt_o(pend_a), .ref_row_o(row_a)
   );

   refresh_sched #(
      .CLK_MHZ(CLK_MHZ), .ROWS(ROWS), .STD_RET_US(STD_US), .EXT_RET_US(EXT_US),
      .PEND_W(PEND_W), .PEND_MAX(PEND_MAX), .ROW_ADDR_EN(1'b0), .COUNT_ACCESS(1'b0)
   ) dut_nc (
      .clk(clk), .rst_n(rst_n), .ext_ret_i(mode_in), .ref_ack_i(ack), .host_cycle_i(acc),
      .ref_req_o(req_c), .ref_urgent_o(urg_c), .pend_cnt_o(pend_c), .ref_row_o(row_c)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // Compare outputs with the model, advance the model over one edge, move to next negedge.
   task automatic cycle(input string tag);
      chk({tag, " pend"}, int'(pend_a), m_pend[0]);
      chk("R4 req", int'(req_a), int'(m_pend[0] != 0));
      chk("R6 urgent", int'(urg_a), int'(m_pend[0] == PEND_MAX));
      chk("R7 row", int'(row_a), m_row[0]);
      chk({tag, " pend no-credit"}, int'(pend_c), m_pend[1]);
      chk("R4 req no-credit", int'(req_c), int'(m_pend[1] != 0));
      chk("R6 urgent no-credit", int'(urg_c), int'(m_pend[1] == PEND_MAX));
      chk("R7 row held zero", int'(row_c), 0);
      for (int i = 0; i < 2; i++) begin
         int  lim;
         bit  tk, dec, stp;
         int  np;
         lim = (m_mode[i] != 0) ? LIM_E : LIM_S;
         tk  = (m_cnt[i] >= lim - 1);
         dec = (ack || (i == 0 && acc)) && (m_pend[i] != 0);
         stp = ack && (m_pend[i] != 0);
         np  = m_pend[i];
         if (tk && !dec && np < PEND_MAX) np++;
         else if (!tk && dec) np--;
         if (m_pend[i] == 0) m_mode[i] = int'(mode_in);
         m_cnt[i]  = tk ? 0 : m_cnt[i] + 1;
         m_pend[i] = np;
         if (stp && i == 0) m_row[i] = (m_row[i] + 1) % ROWS;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < 2; i++) begin
         m_cnt[i] = 0; m_pend[i] = 0; m_mode[i] = 0; m_row[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk("R1 reset pend", int'(pend_a), 0);
      chk("R1 reset req", int'(req_a), 0);
      chk("R1 reset urgent", int'(urg_a), 0);
      chk("R1 reset row", int'(row_a), 0);
      rst_n = 1'b1;

      // R2: first slot exactly LIM_S edges after release, then every LIM_S
      repeat (LIM_S - 1) cycle("R2");
      chk("R2 before first slot", int'(pend_a), 0);
      repeat (1) cycle("R2");
      chk("R2 first slot", int'(pend_a), 1);
      repeat (LIM_S * 2) cycle("R2");
      chk("R2 three slots", int'(pend_a), 3);

      // R6: saturate
      repeat (LIM_S * 8) cycle("R6");
      chk("R6 saturated", int'(pend_a), PEND_MAX);
      chk("R6 urgent set", int'(urg_a), 1);

      // R8: request extended window while backlog is non-zero
      mode_in = 1'b1;
      repeat (LIM_S * 2) cycle("R8");
      chk("R8 standard timing kept", int'(pend_a), PEND_MAX);
      ack = 1'b1;
      repeat (12) cycle("R5");
      chk("R5 drained", int'(pend_a), 0);
      ack = 1'b0;

      // R3: extended slots
      repeat (LIM_E * 2) cycle("R3");
      ack = 1'b1;
      cycle("R5");
      ack = 1'b0;

      // R7: prompt service, full row wrap
      mode_in = 1'b0;
      ack = 1'b1;
      repeat (LIM_E + LIM_S * 20) cycle("R7");
      ack = 1'b0;

      // R9: host cycles credited only on the credit build
      repeat (LIM_S * 3) cycle("R9");
      acc = 1'b1;
      repeat (LIM_S * 2) cycle("R9");
      chk("R9 credit drains", int'(pend_a), 0);
      chk("R9 no credit keeps backlog", int'(pend_c), m_pend[1]);
      acc = 1'b0;

      // R10: mixed stimulus including slot/ack coincidence
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ack     = lfsr[0] & lfsr[3] & lfsr[6];
         acc     = lfsr[5] & lfsr[9] & lfsr[2];
         mode_in = (n / 700) % 2 == 1;
         cycle("R10");
      end
      ack = 1'b0; acc = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule